// File: doc/BRIEF.md
# Prefetch Request Dispatch Unit

This block takes one decoded prefetch operation at a time and decides its fate: a read-to-share bus request, a read-to-own bus request, an illegal-instruction trap, or a silent retire. The outcome depends on two things. The first is the range that the 5-bit function code falls in. The second is whether the external cache already holds the target line in a coherence state that makes the prefetch pointless. A strap input selects between a legacy core variant, where every hint code is a no-op, and an enhanced variant, where hint codes turn into bus traffic.

An operation is accepted on a valid/ready handshake. One cycle later, while the unit is in its lookup state, the unit samples the result of the external tag lookup: a hit flag and a two-bit line state. A bus request is then held until it is acknowledged. Every operation ends with a single-cycle retire pulse. A trap operation also raises a single-cycle trap pulse in that same cycle. Only one operation is in flight at a time.

Top module: `pf_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_req`, `trap_pulse` and `retire_pulse` are 0.
- R2: In legacy mode (`mode_enh`=0), function codes 0 to 4 retire with no bus request and no trap, whatever the tag inputs show.
- R3: In enhanced mode, codes 0, 1 and 2 treat the line as absent when `tag_hit`=0, or when `tag_hit`=1 with `tag_state`=0 (Invalid). An absent line issues a read-to-share request: `bus_req`=1, `bus_own`=0, and `bus_addr` equal to the accepted `req_addr`.
- R4: In enhanced mode, codes 0 to 2 retire with no bus request when `tag_hit`=1 and `tag_state` is 1 (Shared), 2 (Exclusive) or 3 (Modified).
- R5: In enhanced mode, codes 3 and 4 retire with no bus request when `tag_hit`=1 and `tag_state` is 2 or 3. In every other case (a miss, Invalid, or Shared) they issue a read-to-own request: `bus_req`=1, `bus_own`=1.
- R6: Codes 5 to 15 raise `trap_pulse` for exactly one cycle in both modes. This happens in the same cycle as `retire_pulse`, and no bus request is issued.
- R7: Codes 16 to 31 retire with no bus request and no trap in both modes.
- R8: `req_ready` is 0 from the cycle after an acceptance until the operation has retired. Holding `req_valid` high during that time starts no further operation.
- R9: A bus request holds `bus_req`, `bus_own` and `bus_addr` steady until `bus_ack` is seen. `retire_pulse` is then asserted in the next cycle, with `bus_req` low.
- R10: Each operation produces exactly one single-cycle `retire_pulse`. The tag inputs are sampled in the cycle after acceptance, and `retire_pulse` follows two cycles after acceptance for the paths with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Issue side: operation offered |
| req_ready | output | 1 | Issue side: unit can accept |
| req_fcn | input | 5 | Prefetch function code |
| req_addr | input | ADDR_W | Physical line address |
| mode_enh | input | 1 | 1 = enhanced variant, 0 = legacy |
| tag_hit | input | 1 | External cache tag hit, sampled in lookup |
| tag_state | input | 2 | Line state: 0 I, 1 S, 2 E, 3 M |
| bus_req | output | 1 | Bus request pending |
| bus_own | output | 1 | 1 = read-to-own, 0 = read-to-share |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_ack | input | 1 | Bus accepted the request |
| trap_pulse | output | 1 | Illegal-instruction trap, one cycle |
| retire_pulse | output | 1 | Operation retired, one cycle |

## Verification
The assertions check the handshake properties on every cycle. A request stays stable until it is acknowledged, an acknowledge leads to a retire with the request dropped, the trap and retire pulses are single cycles, a trap never coincides with a request, and ready stays low while work is in flight. What the assertions cannot see is which action is right for a given code, mode and line state. The bench scenarios show this by walking every code range in both modes against misses, Invalid hits and each valid state, with acknowledges arriving at different delays.

// File: rtl/pf_pkg.sv
// Package: shared types for the prefetch dispatch unit.
// Assumes: line-state encoding 0 I, 1 S, 2 E, 3 M from the tag lookup.
package pf_pkg;
    typedef enum logic [1:0] {
        CLS_NOP   = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_SHARE = 2'd2,
        CLS_OWN   = 2'd3
    } pf_cls_t;

    typedef enum logic [1:0] {
        ACT_RETIRE  = 2'd0,
        ACT_TRAP    = 2'd1,
        ACT_BUS_SH  = 2'd2,
        ACT_BUS_OWN = 2'd3
    } pf_act_t;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } pf_lstate_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_DONE   = 3'd4
    } pf_state_t;
endpackage

// File: rtl/pf_decode.sv
// Module: pf_decode
// Classifies a function code by range and core variant.
// Assumes: codes up to HINT_MAX are hints, up to TRAP_MAX are illegal,
// the rest are no-ops; among hints, up to SHARE_MAX carry read intent.
module pf_decode
    import pf_pkg::*;
#(
    parameter int FCN_W     = 5,
    parameter int SHARE_MAX = 2,
    parameter int HINT_MAX  = 4,
    parameter int TRAP_MAX  = 15
) (
    input  logic [FCN_W-1:0] fcn,
    input  logic             enh,
    output pf_cls_t          cls
);
    localparam logic [FCN_W-1:0] SH_LIM = FCN_W'(SHARE_MAX);
    localparam logic [FCN_W-1:0] HI_LIM = FCN_W'(HINT_MAX);
    localparam logic [FCN_W-1:0] TR_LIM = FCN_W'(TRAP_MAX);

    // Range decode of the function code.
    always_comb begin
        if (fcn <= HI_LIM) begin
            if (!enh)
                cls = CLS_NOP;
            else if (fcn <= SH_LIM)
                cls = CLS_SHARE;
            else
                cls = CLS_OWN;
        end else if (fcn <= TR_LIM) begin
            cls = CLS_TRAP;
        end else begin
            cls = CLS_NOP;
        end
    end
endmodule

// File: rtl/pf_filter.sv
// Module: pf_filter
// Turns an operation class and the tag lookup result into an action.
// Assumes: a hit with Invalid state counts as a miss; only E or M
// satisfy write intent, any valid state satisfies read intent.
module pf_filter
    import pf_pkg::*;
(
    input  pf_cls_t    cls,
    input  logic       hit,
    input  logic [1:0] lstate,
    output pf_act_t    act
);
    logic present;
    logic owned;

    // Qualify the hit by line state.
    always_comb begin
        present = hit && (pf_lstate_t'(lstate) != LS_I);
        owned   = hit && ((pf_lstate_t'(lstate) == LS_E) ||
                          (pf_lstate_t'(lstate) == LS_M));
    end

    // Pick the action for the class.
    always_comb begin
        unique case (cls)
            CLS_TRAP:  act = ACT_TRAP;
            CLS_SHARE: act = present ? ACT_RETIRE : ACT_BUS_SH;
            CLS_OWN:   act = owned   ? ACT_RETIRE : ACT_BUS_OWN;
            default:   act = ACT_RETIRE;
        endcase
    end
endmodule

// File: rtl/pf_fsm.sv
// Module: pf_fsm
// Sequences one operation: accept, look up, optional bus request, retire.
// Assumes: tag inputs are valid during the lookup cycle; bus_ack is only
// meaningful while bus_req is high.
module pf_fsm
    import pf_pkg::*;
#(
    parameter int FCN_W  = 5,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FCN_W-1:0]  req_fcn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mode_enh,
    output logic [FCN_W-1:0]  fcn_q,
    output logic              enh_q,
    input  pf_act_t           act_in,
    output logic              bus_req,
    output logic              bus_own,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    output logic              trap_pulse,
    output logic              retire_pulse
);
    pf_state_t         state, state_nx;
    pf_act_t           act_q;
    logic [ADDR_W-1:0] addr_q;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = ((act_in == ACT_BUS_SH) || (act_in == ACT_BUS_OWN))
                                  ? ST_ISSUE : ST_DONE;
            ST_ISSUE:  state_nx = bus_ack ? ST_DONE : ST_WAIT;
            ST_WAIT:   if (bus_ack) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the operation on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcn_q  <= '0;
            enh_q  <= 1'b0;
            addr_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            fcn_q  <= req_fcn;
            enh_q  <= mode_enh;
            addr_q <= req_addr;
        end
    end

    // Capture the chosen action at the end of lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)                 act_q <= ACT_RETIRE;
        else if (state == ST_LOOKUP) act_q <= act_in;
    end

    // Output decode.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        bus_req      = (state == ST_ISSUE) || (state == ST_WAIT);
        bus_own      = bus_req && (act_q == ACT_BUS_OWN);
        bus_addr     = bus_req ? addr_q : '0;
        retire_pulse = (state == ST_DONE);
        trap_pulse   = (state == ST_DONE) && (act_q == ACT_TRAP);
    end
endmodule

// File: rtl/pf_dispatch.sv
// Module: pf_dispatch (top)
// Prefetch request dispatch: ties decode, tag filter and sequencer.
// Assumes: one operation at a time; tag result valid in the lookup cycle.
module pf_dispatch
    import pf_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [4:0]        req_fcn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              mode_enh,
    input  logic              tag_hit,
    input  logic [1:0]        tag_state,
    output logic              bus_req,
    output logic              bus_own,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    output logic              trap_pulse,
    output logic              retire_pulse
);
    localparam int FCN_W = 5;

    logic [FCN_W-1:0] fcn_q;
    logic             enh_q;
    pf_cls_t          cls;
    pf_act_t          act;

    pf_decode #(.FCN_W(FCN_W)) u_decode (
        .fcn (fcn_q),
        .enh (enh_q),
        .cls (cls)
    );

    pf_filter u_filter (
        .cls    (cls),
        .hit    (tag_hit),
        .lstate (tag_state),
        .act    (act)
    );

    pf_fsm #(.FCN_W(FCN_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_fcn      (req_fcn),
        .req_addr     (req_addr),
        .mode_enh     (mode_enh),
        .fcn_q        (fcn_q),
        .enh_q        (enh_q),
        .act_in       (act),
        .bus_req      (bus_req),
        .bus_own      (bus_own),
        .bus_addr     (bus_addr),
        .bus_ack      (bus_ack),
        .trap_pulse   (trap_pulse),
        .retire_pulse (retire_pulse)
    );
endmodule

// File: rtl/pf_dispatch_chk.sv
// Module: pf_dispatch_chk
// Port-level protocol checks for pf_dispatch, attached by bind.
module pf_dispatch_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_req,
    input logic              bus_own,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              trap_pulse,
    input logic              retire_pulse
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_own) && $stable(bus_addr))); // R9
    AST_ACK_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (retire_pulse && !bus_req)); // R9
    AST_TRAP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> !bus_req); // R6
    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse); // R6
    AST_TRAP_WITH_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> retire_pulse); // R6
    AST_RETIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_pulse |=> !retire_pulse); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || retire_pulse) |-> !req_ready); // R8
    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

bind pf_dispatch pf_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bus_req      (bus_req),
    .bus_own      (bus_own),
    .bus_addr     (bus_addr),
    .bus_ack      (bus_ack),
    .trap_pulse   (trap_pulse),
    .retire_pulse (retire_pulse)
);

// File: tb/tb_pf_dispatch.sv
// Directed bench for pf_dispatch; one task per scenario.
module tb_pf_dispatch;
    localparam int ADDR_W = 40;
    localparam int K_RET = 0, K_TRAP = 1, K_SH = 2, K_OWN = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [4:0]        req_fcn = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              mode_enh = 1'b0;
    logic              tag_hit = 1'b0;
    logic [1:0]        tag_state = '0;
    logic              bus_req, bus_own, trap_pulse, retire_pulse;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pf_dispatch #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_fcn(req_fcn), .req_addr(req_addr), .mode_enh(mode_enh),
        .tag_hit(tag_hit), .tag_state(tag_state), .bus_req(bus_req),
        .bus_own(bus_own), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .trap_pulse(trap_pulse), .retire_pulse(retire_pulse)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One operation; kind is the expected outcome; ack arrives after dly cycles.
    task automatic run_op(input logic enh, input int fcn, input logic hit,
                          input int st, input int kind, input int dly,
                          input logic [ADDR_W-1:0] addr, input string tag);
        mode_enh  = enh;
        req_fcn   = 5'(fcn);
        req_addr  = addr;
        req_valid = 1'b1;
        chk(req_ready, {tag, " ready before accept"}, req_ready, 1);
        step();
        req_valid = 1'b0;
        req_addr  = '0;
        tag_hit   = hit;
        tag_state = 2'(st);
        chk(!req_ready, {tag, " R8 ready low in lookup"}, req_ready, 0);
        step();
        tag_hit   = 1'b0;
        tag_state = 2'd0;
        if (kind == K_SH || kind == K_OWN) begin
            chk(bus_req, {tag, " bus_req"}, bus_req, 1);
            chk(bus_own == (kind == K_OWN), {tag, " bus_own"}, bus_own, kind == K_OWN);
            chk(bus_addr == addr, {tag, " bus_addr"}, bus_addr, addr);
            for (int i = 0; i < dly; i++) begin
                step();
                chk(bus_req && bus_addr == addr && !retire_pulse,
                    {tag, " R9 hold until ack"}, bus_req, 1);
            end
            bus_ack = 1'b1;
            step();
            bus_ack = 1'b0;
            chk(retire_pulse && !bus_req, {tag, " R9 retire after ack"}, retire_pulse, 1);
            chk(!trap_pulse, {tag, " no trap"}, trap_pulse, 0);
        end else begin
            chk(!bus_req, {tag, " no bus_req"}, bus_req, 0);
            chk(retire_pulse, {tag, " R10 retire 2 cycles after accept"}, retire_pulse, 1);
            chk(trap_pulse == (kind == K_TRAP), {tag, " trap"}, trap_pulse, kind == K_TRAP);
        end
        step();
        chk(!retire_pulse && !trap_pulse, {tag, " R10 R6 single-cycle pulses"},
            retire_pulse, 0);
        chk(req_ready, {tag, " ready after retire"}, req_ready, 1);
    endtask

    task automatic t_reset();
        chk(req_ready && !bus_req && !trap_pulse && !retire_pulse,
            "R1 reset state", {bus_req, trap_pulse, retire_pulse}, 0);
    endtask

    task automatic t_legacy();
        for (int f = 0; f <= 4; f++) begin
            run_op(1'b0, f, 1'b0, 0, K_RET, 0, 40'h100 + f, "R2 legacy miss");
            run_op(1'b0, f, 1'b1, 1, K_RET, 0, 40'h200 + f, "R2 legacy shared");
        end
    endtask

    task automatic t_share();
        for (int f = 0; f <= 2; f++) begin
            run_op(1'b1, f, 1'b0, 3, K_SH, f, 40'hA_0000_1000 + f, "R3 miss");
            run_op(1'b1, f, 1'b1, 0, K_SH, 1, 40'hB_0000_2000 + f, "R3 invalid hit");
            for (int s = 1; s <= 3; s++)
                run_op(1'b1, f, 1'b1, s, K_RET, 0, 40'h300, "R4 present");
        end
    endtask

    task automatic t_own();
        for (int f = 3; f <= 4; f++) begin
            run_op(1'b1, f, 1'b0, 0, K_OWN, 0, 40'hC_1234_0040, "R5 miss");
            run_op(1'b1, f, 1'b1, 0, K_OWN, 2, 40'hD_0000_0080, "R5 invalid");
            run_op(1'b1, f, 1'b1, 1, K_OWN, 3, 40'hE_0000_00C0, "R5 shared");
            run_op(1'b1, f, 1'b1, 2, K_RET, 0, 40'h400, "R5 exclusive");
            run_op(1'b1, f, 1'b1, 3, K_RET, 0, 40'h400, "R5 modified");
        end
    endtask

    task automatic t_trap();
        for (int f = 5; f <= 15; f++) begin
            run_op(1'b0, f, 1'b0, 0, K_TRAP, 0, 40'h500, "R6 trap legacy");
            run_op(1'b1, f, 1'b0, 0, K_TRAP, 0, 40'h500, "R6 trap enhanced");
        end
    endtask

    task automatic t_nop_high();
        for (int f = 16; f <= 31; f++) begin
            run_op(1'b0, f, 1'b0, 0, K_RET, 0, 40'h600, "R7 legacy");
            run_op(1'b1, f, 1'b0, 0, K_RET, 0, 40'h600, "R7 enhanced");
        end
    endtask

    // Valid held high while busy must not start a second operation.
    task automatic t_busy();
        mode_enh  = 1'b1;
        req_fcn   = 5'd0;
        req_addr  = 40'h7_0000_0000;
        req_valid = 1'b1;
        step();
        tag_hit = 1'b0;
        req_fcn = 5'd3;
        step();
        chk(bus_req && !bus_own && !req_ready, "R8 busy first request", bus_req, 1);
        step();
        step();
        chk(bus_req && bus_addr == 40'h7_0000_0000, "R8 held while valid high", bus_addr, 40'h7_0000_0000);
        req_valid = 1'b0;
        bus_ack   = 1'b1;
        step();
        bus_ack = 1'b0;
        chk(retire_pulse && !bus_req, "R8 retire", retire_pulse, 1);
        step();
        chk(req_ready && !bus_req, "R8 idle, no second op", bus_req, 0);
        step();
        chk(!bus_req && !retire_pulse, "R8 nothing started", retire_pulse, 0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_legacy();
        t_share();
        t_own();
        t_trap();
        t_nop_high();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule